// File: doc/BRIEF.md
# Bit-Serial Cascaded FIR Filter

This block is a finite impulse response filter made from a chain of identical tap cells. Each cell holds one stage of the sample delay line and one coefficient. It multiplies the two by stepping through the sample one bit per clock, least significant bit first. A cascade adder then sums the per-cell products. The full-precision sum is rounded and saturated to a 16-bit result. One sample enters per 16-clock frame, and the matching result leaves on a one-cycle strobe. The cost of the datapath grows linearly with the tap count, and a longer filter is built by raising the tap parameter.

Coefficients are written one at a time into a shadow bank through an address/data/write-enable port. A commit pulse arms a swap. At the next accepted sample, the whole shadow bank is copied into the active bank. That sample is the first one to use the new set, so every tap changes together between two input samples. This makes the block usable as the datapath of an adaptive filter whose taps are updated once per sample.

Top module: `fir_serial_top`

## Requirements
- R1: A synchronous reset clears the delay line, all coefficients (shadow and active), out_data and out_valid, and leaves in_ready high. Until the first commit, every output is 0.
- R2: in_ready is high only at a frame boundary. After a sample is accepted (in_valid and in_ready high at a clock edge), in_ready is low for the next 15 cycles and high again after the 15th edge that follows the accept.
- R3: For a sample accepted at edge E, out_valid is high for exactly one cycle, the cycle after edge E+16, and is low in the cycle after edge E+15 and in the cycle after edge E+17.
- R4: The result is y = sum over k of c[k]·x[n-k], where x[n] is the newest accepted sample and c[0] is at address 0. Samples and coefficients are 16-bit two's complement, and coefficients carry 15 fraction bits (Q15).
- R5: Rounding is round-half-up: the value output is floor((sum + 2^14) / 2^15). So a sum of +0.5 LSB gives 1, and a sum of −0.5 LSB gives 0.
- R6: A rounded value above 32767 gives 32767, and one below −32768 gives −32768. This includes the case (−32768)·(−32768).
- R7: A shadow coefficient write does not change any output until a commit is followed by an accepted sample.
- R8: After a commit, the whole shadow bank takes effect at the next accepted sample, including that sample's own result. Writes made between the commit and that sample are included.
- R9: in_valid while in_ready is low is ignored: that data never enters the delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | High at a frame boundary, when a sample can be taken |
| in_data | input | 16 | Input sample, two's complement |
| cf_we | input | 1 | Shadow coefficient write enable |
| cf_addr | input | 4 | Tap index of the shadow write |
| cf_data | input | 16 | Coefficient value, Q15 two's complement |
| cf_commit | input | 1 | Arms the copy of the shadow bank at the next accepted sample |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | 16 | Rounded, saturated filter output |

## Verification
The serial multipliers are exercised with several kinds of sample: positive and negative values, alternating signs, the most negative value, and values on either side of a half-LSB sum. Together these separate a correct negative weight on the top sample bit from a wrong one, and separate half-up rounding from truncation. A mixed-sign coefficient set with all taps active catches a wrongly ordered delay line or a dropped cascade term. Single-tap sets isolate the rounding point and the clamp in both directions. Uncommitted writes, writes made after a commit, and stray in_valid during a busy frame show whether the coefficient swap and the input gate happen only at the frame boundary.

// File: rtl/fir_pkg.sv
package fir_pkg;

    localparam int FIR_SAMPLE_W = 16;
    localparam int FIR_NUM_TAPS = 16;

    // Per-cycle control broadcast from the frame sequencer to every cell.
    typedef struct packed {
        logic load;   // frame boundary: new sample enters, bit 0 handled
        logic step;   // one of the remaining bits is being handled
        logic last;   // the sign bit (negative weight) is being handled
        logic fin;    // all products are complete this cycle
    } fir_ctl_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } fir_phase_e;

endpackage

// File: rtl/fir_frame_seq.sv
module fir_frame_seq
    import fir_pkg::*;
#(
    parameter int BITS = FIR_SAMPLE_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    output logic     ready,
    output fir_ctl_t ctl
);
    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BITS - 1);

    fir_phase_e       phase;
    logic [CNT_W-1:0] bit_idx;
    logic             fin_q;
    logic             accept;

    assign ready  = (phase == PH_IDLE);
    assign accept = ready && in_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= (phase == PH_RUN) && (bit_idx == LAST_IDX);
            if (accept) begin
                phase   <= PH_RUN;
                bit_idx <= CNT_W'(1);
            end else if (phase == PH_RUN) begin
                if (bit_idx == LAST_IDX) begin
                    phase   <= PH_IDLE;
                    bit_idx <= '0;
                end else begin
                    bit_idx <= bit_idx + CNT_W'(1);
                end
            end
        end
    end

    always_comb begin
        ctl.load = accept;
        ctl.step = (phase == PH_RUN);
        ctl.last = (phase == PH_RUN) && (bit_idx == LAST_IDX);
        ctl.fin  = fin_q;
    end

    // R2: a busy frame always runs to its last bit before returning to idle
    a_r2_run_advances: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && bit_idx != LAST_IDX) |=> (phase == PH_RUN));

    // R3: completion follows the last bit by one cycle
    a_r3_fin_after_last: assert property (@(posedge clk) disable iff (rst)
        ctl.last |=> fin_q);

endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank
    import fir_pkg::*;
#(
    parameter int TAPS = FIR_NUM_TAPS,
    parameter int CW   = FIR_SAMPLE_W,
    localparam int AW  = $clog2(TAPS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [CW-1:0]             wr_data,
    input  logic                      commit,
    input  logic                      swap_slot,
    output logic [TAPS-1:0][CW-1:0]   coef_use
);
    logic [TAPS-1:0][CW-1:0] shadow_q;
    logic [TAPS-1:0][CW-1:0] active_q;
    logic                    armed_q;
    logic                    take;

    assign take = armed_q || commit;

    for (genvar k = 0; k < TAPS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[k] <= '0;
            end else if (wr_en && wr_addr == AW'(k)) begin
                shadow_q[k] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                active_q[k] <= '0;
            end else if (swap_slot && take) begin
                active_q[k] <= shadow_q[k];
            end
        end

        assign coef_use[k] = take ? shadow_q[k] : active_q[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (swap_slot) begin
            armed_q <= 1'b0;
        end else if (commit) begin
            armed_q <= 1'b1;
        end
    end

    // R7: the active set only moves at a sample boundary
    a_r7_active_hold: assert property (@(posedge clk) disable iff (rst)
        !swap_slot |=> $stable(active_q));

    // R8: an armed swap stays armed until a sample arrives
    a_r8_armed_kept: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !swap_slot) |=> armed_q);

endmodule

// File: rtl/fir_tap_cell.sv
module fir_tap_cell
    import fir_pkg::*;
#(
    parameter int W = FIR_SAMPLE_W,
    localparam int PW = 2 * W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  fir_ctl_t             ctl,
    input  logic signed [W-1:0]  x_in,
    input  logic signed [W-1:0]  coef_in,
    output logic signed [W-1:0]  tap_out,
    output logic signed [PW-1:0] prod
);
    logic signed [W-1:0]  tap_q;
    logic        [W-1:0]  xbits_q;
    logic signed [PW-1:0] mcand_q;
    logic signed [PW-1:0] prod_q;
    logic signed [PW-1:0] coef_sx;

    assign coef_sx = PW'(coef_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q   <= '0;
            xbits_q <= '0;
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (ctl.load) begin
            tap_q   <= x_in;
            xbits_q <= x_in >> 1;
            mcand_q <= coef_sx <<< 1;
            prod_q  <= x_in[0] ? coef_sx : '0;
        end else if (ctl.step) begin
            if (xbits_q[0]) begin
                prod_q <= ctl.last ? (prod_q - mcand_q) : (prod_q + mcand_q);
            end
            mcand_q <= mcand_q <<< 1;
            xbits_q <= xbits_q >> 1;
        end
    end

    assign tap_out = tap_q;
    assign prod    = prod_q;

    // R9: the delay stage moves only when a sample is accepted
    a_r9_tap_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl.load |=> $stable(tap_q));

    // R4: the product stays put once the frame is over
    a_r4_prod_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.step) |=> $stable(prod_q));

endmodule

// File: rtl/fir_serial_top.sv
module fir_serial_top
    import fir_pkg::*;
#(
    parameter int W      = FIR_SAMPLE_W,
    parameter int TAPS   = FIR_NUM_TAPS,
    parameter int FRAC_W = W - 1,
    localparam int AW    = $clog2(TAPS),
    localparam int PW    = 2 * W,
    localparam int ACC_W = PW + $clog2(TAPS) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_data,
    input  logic          cf_we,
    input  logic [AW-1:0] cf_addr,
    input  logic [W-1:0]  cf_data,
    input  logic          cf_commit,
    output logic          out_valid,
    output logic [W-1:0]  out_data
);
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] OUT_MAX  = (ACC_W'(1) <<< (W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] OUT_MIN  = -(ACC_W'(1) <<< (W - 1));

    fir_ctl_t                  ctl;
    logic                      ready;
    logic [TAPS-1:0][W-1:0]    coef_use;
    logic signed [W-1:0]       tap_vals [TAPS];
    logic signed [PW-1:0]      prods    [TAPS];
    logic signed [ACC_W-1:0]   psum     [TAPS];
    logic signed [ACC_W-1:0]   rounded;
    logic [W-1:0]              out_next;
    logic                      out_valid_q;
    logic [W-1:0]              out_data_q;

    fir_frame_seq #(.BITS(W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .ready    (ready),
        .ctl      (ctl)
    );

    fir_coef_bank #(.TAPS(TAPS), .CW(W)) u_coef (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cf_we),
        .wr_addr   (cf_addr),
        .wr_data   (cf_data),
        .commit    (cf_commit),
        .swap_slot (ctl.load),
        .coef_use  (coef_use)
    );

    for (genvar k = 0; k < TAPS; k++) begin : g_cell
        logic signed [W-1:0] x_feed;
        if (k == 0) begin : g_head
            assign x_feed = in_data;
        end else begin : g_link
            assign x_feed = tap_vals[k-1];
        end

        fir_tap_cell #(.W(W)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl),
            .x_in    (x_feed),
            .coef_in (coef_use[k]),
            .tap_out (tap_vals[k]),
            .prod    (prods[k])
        );

        if (k == 0) begin : g_sum0
            assign psum[k] = ACC_W'(prods[k]);
        end else begin : g_sumk
            assign psum[k] = psum[k-1] + ACC_W'(prods[k]);
        end
    end

    assign rounded = (psum[TAPS-1] + HALF_LSB) >>> FRAC_W;

    always_comb begin
        if (rounded > OUT_MAX) begin
            out_next = OUT_MAX[W-1:0];
        end else if (rounded < OUT_MIN) begin
            out_next = OUT_MIN[W-1:0];
        end else begin
            out_next = rounded[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
        end else begin
            out_valid_q <= ctl.fin;
            if (ctl.fin) begin
                out_data_q <= out_next;
            end
        end
    end

    assign in_ready  = ready;
    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;

    // R1: the first cycle after reset shows a cleared output
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0 && in_ready));

    // R2: an accepted sample closes the input for the frame
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R3: the result strobe lasts a single cycle
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R3: output data only changes together with the strobe
    a_r3_data_with_strobe: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

endmodule

// File: tb/sim_fir_serial_top.sv
module sim_fir_serial_top;

    localparam int W    = 16;
    localparam int TAPS = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_ready;
    logic [W-1:0]  in_data;
    logic          cf_we;
    logic [3:0]    cf_addr;
    logic [W-1:0]  cf_data;
    logic          cf_commit;
    logic          out_valid;
    logic [W-1:0]  out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int act_c [TAPS];
    int shd_c [TAPS];
    int hist  [TAPS];
    bit armed = 0;

    always #5 clk = ~clk;

    fir_serial_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data),
        .cf_commit(cf_commit), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(string req, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int model_out();
        longint s = 0;
        longint r;
        for (int k = 0; k < TAPS; k++) s += longint'(act_c[k]) * longint'(hist[k]);
        r = (s + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic write_coef(int idx, int val);
        @(negedge clk);
        cf_we = 1; cf_addr = 4'(idx); cf_data = 16'(val);
        @(negedge clk);
        cf_we = 0;
        shd_c[idx] = val;
    endtask

    task automatic pulse_commit();
        @(negedge clk);
        cf_commit = 1;
        @(negedge clk);
        cf_commit = 0;
        armed = 1;
    endtask

    task automatic clear_shadow();
        for (int k = 0; k < TAPS; k++) write_coef(k, 0);
    endtask

    // Offers one sample at a frame boundary; optionally drives stray data mid-frame.
    task automatic run_sample(int val, string req, bit noise);
        int exp;
        @(negedge clk);
        check("R2 ready at boundary", in_ready, 1);
        in_valid = 1; in_data = 16'(val);
        @(posedge clk);
        if (armed) begin
            for (int k = 0; k < TAPS; k++) act_c[k] = shd_c[k];
            armed = 0;
        end
        for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = val;
        exp = model_out();
        @(negedge clk);
        in_valid = 0;
        check("R2 ready low after accept", in_ready, 0);
        if (noise) begin
            in_valid = 1; in_data = 16'(12345);
        end
        repeat (5) @(negedge clk);
        in_valid = 0;
        repeat (9) @(negedge clk);
        check("R2 ready low at 15th cycle", in_ready, 0);
        @(negedge clk);
        check("R2 ready back after frame", in_ready, 1);
        check("R3 no strobe before result", out_valid, 0);
        @(negedge clk);
        check("R3 strobe with result", out_valid, 1);
        check(req, longint'($signed(out_data)), longint'(exp));
        @(negedge clk);
        check("R3 strobe one cycle", out_valid, 0);
    endtask

    task automatic t_reset();
        check("R1 out_data after reset", out_data, 0);
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 in_ready after reset", in_ready, 1);
        run_sample(30000, "R1 zero coefficients", 0);
        run_sample(-20000, "R1 zero coefficients", 0);
    endtask

    task automatic t_shadow_only();
        write_coef(0, 16384);
        write_coef(1, 8000);
        run_sample(1000, "R7 uncommitted write", 0);
        run_sample(2000, "R7 uncommitted write", 0);
    endtask

    task automatic t_commit_set();
        pulse_commit();
        write_coef(2, -12000);   // after commit, before sample: included (R8)
        run_sample(1000, "R8 set applies at next sample", 0);
        run_sample(-3000, "R8 set in use", 0);
    endtask

    task automatic t_full_taps();
        for (int k = 0; k < TAPS; k++) write_coef(k, k * 2731 - 20000);
        pulse_commit();
        run_sample(12000, "R4 mixed taps positive", 0);
        run_sample(-32768, "R4 most negative sample", 0);
        run_sample(32767, "R4 alternating sign", 0);
        run_sample(-1, "R4 minus one", 0);
        run_sample(21845, "R4 bit pattern 0101", 0);
        run_sample(-21846, "R4 bit pattern 1010", 0);
    endtask

    task automatic t_ignore();
        run_sample(500, "R9 stray valid mid-frame", 1);
        run_sample(700, "R9 stray data not in delay line", 0);
        run_sample(-900, "R9 history intact", 0);
    endtask

    task automatic t_round();
        clear_shadow();
        write_coef(0, 1);
        pulse_commit();
        run_sample(16384, "R5 +half rounds up", 0);
        run_sample(16383, "R5 below half rounds down", 0);
        run_sample(-16384, "R5 -half rounds to zero", 0);
        run_sample(-16385, "R5 below -half", 0);
    endtask

    task automatic t_sat();
        write_coef(0, -32768);
        pulse_commit();
        run_sample(-32768, "R6 neg times neg clamps high", 0);
        for (int k = 0; k < TAPS; k++) write_coef(k, 32767);
        pulse_commit();
        run_sample(32767, "R6 positive clamp", 0);
        run_sample(32767, "R6 positive clamp", 0);
        for (int k = 0; k < 4; k++) run_sample(-32768, "R6 negative clamp", 0);
    endtask

    initial begin
        for (int k = 0; k < TAPS; k++) begin
            act_c[k] = 0; shd_c[k] = 0; hist[k] = 0;
        end
        rst = 1; in_valid = 0; in_data = '0;
        cf_we = 0; cf_addr = '0; cf_data = '0; cf_commit = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_shadow_only();
        t_commit_set();
        t_full_taps();
        t_ignore();
        t_round();
        t_sat();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule